// File: doc/BRIEF.md
# GPIO pin interrupt detector

This block watches the eight input pins of one GPIO port and turns chosen pin activity into a single interrupt line. Each pin first passes through a two-flop synchronizer. The block then compares the settled sample with the previous one, or checks its level, against a per-pin trigger setting. When the trigger matches, a per-pin event flag is latched. The flag stays set until software writes a one to its bit in the clear register. Flags are gated by a per-pin mask, and the gated flags are ORed into `irq_o`.

Software sets each pin's trigger with three one-bit-per-pin control registers:
- **level select**: 1 means level-sensitive, 0 means edge-sensitive.
- **dual edge**: in edge mode, 1 means trigger on every transition.
- **polarity**: 1 means high level or rising edge, 0 means low level or falling edge.

Every register holds one bit per pin, so any group of pins can be set up in one write. The register port is plain: a write takes effect at the clock edge on which `wr_en` is high, and read data is combinational from `addr`. The port has no handshake and never applies back-pressure.

Top module: `gpio_irq_detect`

## Requirements
- R1: Bit i of every register belongs to pin i. The register addresses are:
  - 0: level select (read/write)
  - 1: dual edge (read/write)
  - 2: polarity (read/write)
  - 3: mask (read/write)
  - 4: raw flags (read only)
  - 5: masked flags (read only)
  - 6: clear (write only)

  Writes to addresses 4 and 5 have no effect. Reads of addresses 6 and 7 return 0.
- R2: With level select at 1, a pin raises its flag while its synchronized input equals its polarity bit (0 = low level, 1 = high level).
- R3: With level select at 0 and dual edge at 0, a pin raises its flag on a rising edge when its polarity bit is 1, and on a falling edge when it is 0.
- R4: With level select at 0 and dual edge at 1, a pin raises its flag on both rising and falling edges, whatever its polarity bit holds.
- R5: The masked flags equal the raw flags AND the mask, and `irq_o` is the OR of the masked flags. A masked pin still latches its raw flag.
- R6: A raised flag stays set, with no further pin activity, until it is cleared.
- R7: Writing to the clear register clears each flag whose data bit is 1. Any number of flags can be cleared in one write, and flags whose data bit is 0 are left unchanged.
- R8: If a pin's trigger occurs in the same cycle as a clear write for that pin, its flag stays set.
- R9: If a level-sensitive pin's active level is still present when its flag is cleared, the flag reads as set again on the following cycle.
- R10: After reset, all control, mask and flag registers read 0 and `irq_o` is 0. This means edge mode, falling polarity, all pins masked.
- R11: A pin change applied before clock edge k shows in the raw flags after clock edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Asynchronous pin inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Port interrupt, OR of masked flags |

## Verification
The bench fires a pin trigger in exactly the cycle that a clear write lands. A design that let the clear win would lose that event and read 0.

It clears a level-triggered pin while the level is still held. A design that only latches on a change would then stay clear.

It sets dual edge together with both polarity values. A design that let polarity leak into dual-edge mode would miss the falling or the rising transitions.

It also checks the three-edge latency at both of its ends, writes to the read-only addresses, and clears a partial mask. A wrong synchronizer depth, a writable status register or an over-wide clear each shows up as a wrong flag value.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_LVL_SEL = 3'd0,
    REG_DUAL    = 3'd1,
    REG_POL     = 3'd2,
    REG_MASK    = 3'd3,
    REG_RAW     = 3'd4,
    REG_MSTAT   = 3'd5,
    REG_CLEAR   = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int NPIN   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] pin_s
);
  logic [STAGES-1:0][NPIN-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= '0;
          else        chain_q[g] <= pin_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= '0;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign pin_s = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_trig.sv
module gpio_irq_trig #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_s,
  input  logic [NPIN-1:0] lvl_sel,
  input  logic [NPIN-1:0] dual,
  input  logic [NPIN-1:0] pol,
  input  logic [NPIN-1:0] clr,
  output logic [NPIN-1:0] flag
);
  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] flag_q;
  logic [NPIN-1:0] hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_s;

  genvar g;
  generate
    for (g = 0; g < NPIN; g++) begin : g_pin
      logic rise, fall, lvl_hit, edge_hit;
      always_comb begin
        rise     = pin_s[g] & ~prev_q[g];
        fall     = ~pin_s[g] & prev_q[g];
        lvl_hit  = (pin_s[g] == pol[g]);
        edge_hit = dual[g] ? (rise | fall) : (pol[g] ? rise : fall);
        hit[g]   = lvl_sel[g] ? lvl_hit : edge_hit;
      end

      // trigger wins over a clear in the same cycle
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) flag_q[g] <= 1'b0;
        else        flag_q[g] <= (flag_q[g] & ~clr[g]) | hit[g];

      a_r2_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_sel[g] && (pin_s[g] == pol[g]) |=> flag_q[g]);

      a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_sel[g] && !dual[g] && pol[g] && pin_s[g] && !prev_q[g] |=> flag_q[g]);

      a_r4_dual_sets: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_sel[g] && dual[g] && (pin_s[g] != prev_q[g]) |=> flag_q[g]);

      a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q[g] && !clr[g] |=> flag_q[g]);

      a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clr[g] && (pin_s[g] == prev_q[g]) && !(lvl_sel[g] && pin_s[g] == pol[g])
        |=> !flag_q[g]);

      a_r8_clear_collision: assert property (@(posedge clk) disable iff (!rst_n)
        clr[g] && !lvl_sel[g] && dual[g] && (pin_s[g] != prev_q[g]) |=> flag_q[g]);
    end
  endgenerate

  assign flag = flag_q;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [NPIN-1:0]       wdata,
  input  logic [NPIN-1:0]       raw,
  output logic [NPIN-1:0]       lvl_sel,
  output logic [NPIN-1:0]       dual,
  output logic [NPIN-1:0]       pol,
  output logic [NPIN-1:0]       mask,
  output logic [NPIN-1:0]       clr,
  output logic [NPIN-1:0]       mstat,
  output logic [NPIN-1:0]       rdata
);
  logic [NPIN-1:0] lvl_q, dual_q, pol_q, mask_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_q  <= '0;
      dual_q <= '0;
      pol_q  <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      case (addr)
        REG_LVL_SEL: lvl_q  <= wdata;
        REG_DUAL:    dual_q <= wdata;
        REG_POL:     pol_q  <= wdata;
        REG_MASK:    mask_q <= wdata;
        default:     ;
      endcase
    end

  assign clr   = (wr_en && addr == REG_CLEAR) ? wdata : '0;
  assign mstat = raw & mask_q;

  always_comb begin
    case (addr)
      REG_LVL_SEL: rdata = lvl_q;
      REG_DUAL:    rdata = dual_q;
      REG_POL:     rdata = pol_q;
      REG_MASK:    rdata = mask_q;
      REG_RAW:     rdata = raw;
      REG_MSTAT:   rdata = mstat;
      default:     rdata = '0;
    endcase
  end

  assign lvl_sel = lvl_q;
  assign dual    = dual_q;
  assign pol     = pol_q;
  assign mask    = mask_q;

  a_r1_status_not_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == REG_RAW || addr == REG_MSTAT)
    |=> $stable(lvl_q) && $stable(dual_q) && $stable(pol_q) && $stable(mask_q));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPIN        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPIN-1:0]       pin_i,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [NPIN-1:0]       wdata,
  output logic [NPIN-1:0]       rdata,
  output logic                  irq_o
);
  logic [NPIN-1:0] pin_s, lvl_sel, dual, pol, mask, clr, flag, mstat;

  gpio_irq_sync #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pin_s(pin_s));

  gpio_irq_trig #(.NPIN(NPIN)) u_trig (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .lvl_sel(lvl_sel), .dual(dual),
    .pol(pol), .clr(clr), .flag(flag));

  gpio_irq_regs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .raw(flag), .lvl_sel(lvl_sel), .dual(dual), .pol(pol), .mask(mask),
    .clr(clr), .mstat(mstat), .rdata(rdata));

  assign irq_o = |mstat;

  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq_o);

  a_r5_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag != '0));
endmodule

// File: tb/sim_gpio_irq_detect.sv
module sim_gpio_irq_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_i = '0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_o;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_detect u0 (.clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

  // {lvl_sel, dual, pol, pins_first, pins_second, expected_raw}
  localparam logic [47:0] VEC [8] = '{
    {8'h00, 8'h00, 8'h00, 8'h0F, 8'h33, 8'h0C},
    {8'h00, 8'h00, 8'hFF, 8'h0F, 8'h33, 8'h30},
    {8'h00, 8'hFF, 8'h00, 8'h0F, 8'h33, 8'h3C},
    {8'h00, 8'hFF, 8'hFF, 8'h0F, 8'h33, 8'h3C},
    {8'hFF, 8'h00, 8'h00, 8'h0F, 8'h33, 8'hFC},
    {8'hFF, 8'h00, 8'hFF, 8'h0F, 8'h33, 8'h3F},
    {8'h00, 8'h00, 8'hFF, 8'hAA, 8'h55, 8'h55},
    {8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'hFF}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    string tag;
    idle(3);
    // R10: reset state
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v); chk("R10", v, 8'h00);
    end
    chk("R10 irq", {7'd0, irq_o}, 8'h00);
    rst_n = 1'b1;
    idle(2);

    // R1: status registers ignore writes, clear reads zero
    wr(3'd4, 8'hFF); rd(3'd4, v); chk("R1 raw write", v, 8'h00);
    wr(3'd5, 8'hFF); rd(3'd5, v); chk("R1 mstat write", v, 8'h00);
    rd(3'd6, v); chk("R1 clear read", v, 8'h00);
    wr(3'd2, 8'hA5); rd(3'd2, v); chk("R1 pol readback", v, 8'hA5);

    // table of trigger modes; mask stays 0
    for (int e = 0; e < 8; e++) begin
      wr(3'd0, VEC[e][47:40]);
      wr(3'd1, VEC[e][39:32]);
      wr(3'd2, VEC[e][31:24]);
      pin_i = VEC[e][23:16];
      idle(4);
      wr(3'd6, 8'hFF);
      pin_i = VEC[e][15:8];
      idle(4);
      if (VEC[e][47:40] != 0) tag = "R2";
      else if (VEC[e][39:32] != 0) tag = "R4";
      else tag = "R3";
      rd(3'd4, v); chk(tag, v, VEC[e][7:0]);
      rd(3'd5, v); chk("R5 masked zero", v, 8'h00);
      chk("R5 irq low", {7'd0, irq_o}, 8'h00);
    end

    // R11: latency, edge rise on all pins
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'hFF);
    pin_i = 8'h00; idle(4); wr(3'd6, 8'hFF);
    pin_i = 8'h01;
    idle(2); rd(3'd4, v); chk("R11 early", v, 8'h00);
    idle(1); rd(3'd4, v); chk("R11 on time", v, 8'h01);

    // R5: mask gating
    wr(3'd3, 8'h01);
    rd(3'd5, v); chk("R5 mstat", v, 8'h01);
    chk("R5 irq high", {7'd0, irq_o}, 8'h01);
    wr(3'd3, 8'h02);
    chk("R5 irq masked", {7'd0, irq_o}, 8'h00);
    rd(3'd4, v); chk("R5 raw kept", v, 8'h01);

    // R6: sticky
    idle(10); rd(3'd4, v); chk("R6 sticky", v, 8'h01);

    // R7: partial clear
    pin_i = 8'h0F; idle(4);
    wr(3'd6, 8'h05); rd(3'd4, v); chk("R7 partial", v, 8'h0A);
    wr(3'd6, 8'h0A); rd(3'd4, v); chk("R7 rest", v, 8'h00);

    // R8: clear colliding with a dual-edge event on pin 1
    wr(3'd1, 8'h02);
    pin_i = 8'h0D; idle(4);
    rd(3'd4, v); chk("R8 setup", v, 8'h02);
    pin_i = 8'h0F;
    idle(2);
    wr(3'd6, 8'h02);
    rd(3'd4, v); chk("R8 collision", v, 8'h02);
    wr(3'd6, 8'h02); rd(3'd4, v); chk("R8 then clear", v, 8'h00);

    // R9: level high on pin 2 re-sets after clear
    wr(3'd1, 8'h00); wr(3'd0, 8'h04); wr(3'd2, 8'h04);
    idle(1);
    wr(3'd6, 8'h04); rd(3'd4, v); chk("R9 reassert", v, 8'h04);
    pin_i = 8'h0B; idle(4);
    wr(3'd6, 8'h04); rd(3'd4, v); chk("R9 gone", v, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule